// File: doc/BRIEF.md
# Five-Input Column Compressor Row

This block is one row of a carry-save reduction tree. Every bit column receives four operand bits and one carry from the column just below it. Each column reduces those five bits to three outputs: a sum bit of the same weight, a vertical carry of double weight, and a horizontal carry that goes to the next column up. The row has no clock. It sits between partial-product generation and the final carry-propagate adder, and both of those lie outside it.

Each cell keeps the sum logic and the carry logic apart. The sum is built from two cascaded three-input XOR stages. Each carry is one AND-OR-of-pairs majority term. The horizontal carry leaving a column is formed only from three operand bits of that same column. It never waits on the carry arriving from below, so nothing ripples along the row. The least significant column takes its incoming carry from a top-level pin. The horizontal carry leaving the most significant column is a top-level output.

Top module: `cmp5_row`

## Requirements
- R1: For every column i, `sum_o[i]` is the XOR of `a_i[i]`, `b_i[i]`, `c_i[i]`, `d_i[i]` and that column's incoming carry.
- R2: The horizontal carry leaving column i is 1 exactly when at least two of `a_i[i]`, `b_i[i]`, `c_i[i]` are 1. It does not depend on `d_i` or on the incoming carry.
- R3: `vcarry_o[i]` is the majority of three signals: (`a_i[i]` XOR `b_i[i]` XOR `c_i[i]`), `d_i[i]`, and the incoming carry.
- R4: In every column, the count of ones among the five inputs equals sum + 2 × (vertical carry + horizontal carry).
- R5: Column 0 takes its incoming carry from `cin_i`. Every column i > 0 takes the horizontal carry of column i−1.
- R6: `hcarry_o` is the horizontal carry leaving column N−1.
- R7: Taken as unsigned N-bit integers, A + B + C + D + `cin_i` equals `sum_o` + 2·`vcarry_o` + 2^N·`hcarry_o`.
- R8: Changing only `cin_i` changes nothing except `sum_o[0]` and `vcarry_o[0]`. All columns above 0 and `hcarry_o` stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand bit of each column |
| b_i | input | N | Second operand bit of each column |
| c_i | input | N | Third operand bit of each column |
| d_i | input | N | Fourth operand bit of each column |
| cin_i | input | 1 | Incoming horizontal carry of column 0 |
| sum_o | output | N | Sum bit of each column |
| vcarry_o | output | N | Vertical carry of each column, weight 2 relative to its column |
| hcarry_o | output | 1 | Horizontal carry leaving column N−1 |

## Verification
The immediate assertions in each cell and at the row level assume that every input is a settled two-state value whenever the combinational processes evaluate. They check nothing over time, so they rely on no input order or hold time. The bench drives all inputs together on a rising clock edge and samples on the following falling edge. It never leaves a pin undriven, so every evaluation sees defined 0/1 values. The stimulus covers all 32 input patterns on every column, with the incoming carry supplied through `cin_i` or through the column below. It also applies random full-width vectors.

// File: rtl/cmp5_pkg.sv
`timescale 1ns/1ps
package cmp5_pkg;

  // three-input parity primitive used by the sum path
  function automatic logic xor3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // AND-OR of all pairs: one six-input AO222 gate, i.e. a majority of three
  function automatic logic ao222_maj(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

endpackage

// File: rtl/cmp5_sum_path.sv
`timescale 1ns/1ps
module cmp5_sum_path
  import cmp5_pkg::*;
(
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  output logic part_o,
  output logic sum_o
);

  // first stage: parity of three operand bits; second: fold in x4 and carry
  always_comb begin
    part_o = xor3(x1, x2, x3);
    sum_o  = xor3(part_o, x4, cin);
  end

  // R1: sum equals odd parity of all five inputs
  always_comb begin
    a_r1_sum_parity: assert (sum_o == ($countones({x1, x2, x3, x4, cin}) % 2 == 1))
      else $error("R1 sum parity mismatch");
  end

endmodule

// File: rtl/cmp5_carry_path.sv
`timescale 1ns/1ps
module cmp5_carry_path
  import cmp5_pkg::*;
(
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  input  logic part_i,
  output logic hcarry_o,
  output logic vcarry_o
);

  // horizontal carry uses only this column's operands: no ripple
  always_comb begin
    hcarry_o = ao222_maj(x1, x2, x3);
    vcarry_o = ao222_maj(part_i, x4, cin);
  end

  // R2: horizontal carry set exactly when two or more of x1..x3 are set
  always_comb begin
    a_r2_hcarry_count: assert (hcarry_o == ($countones({x1, x2, x3}) >= 2))
      else $error("R2 horizontal carry mismatch");
  end

endmodule

// File: rtl/cmp5_cell.sv
`timescale 1ns/1ps
module cmp5_cell (
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  output logic sum_o,
  output logic vcarry_o,
  output logic hcarry_o
);

  logic part;

  cmp5_sum_path u_sum (
    .x1     (x1),
    .x2     (x2),
    .x3     (x3),
    .x4     (x4),
    .cin    (cin),
    .part_o (part),
    .sum_o  (sum_o)
  );

  cmp5_carry_path u_carry (
    .x1       (x1),
    .x2       (x2),
    .x3       (x3),
    .x4       (x4),
    .cin      (cin),
    .part_i   (part),
    .hcarry_o (hcarry_o),
    .vcarry_o (vcarry_o)
  );

  // R4: ones count is conserved across the three outputs of the cell
  always_comb begin
    a_r4_cell_count: assert ($countones({x1, x2, x3, x4, cin}) ==
                             int'(sum_o) + 2 * (int'(vcarry_o) + int'(hcarry_o)))
      else $error("R4 cell count not conserved");
  end

  // R3: vertical carry never set while fewer than two inputs are set
  always_comb begin
    a_r3_vcarry_needs_two: assert (!vcarry_o || ($countones({x1, x2, x3, x4, cin}) >= 2))
      else $error("R3 vertical carry with too few inputs");
  end

endmodule

// File: rtl/cmp5_row.sv
`timescale 1ns/1ps
module cmp5_row #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] d_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] vcarry_o,
  output logic         hcarry_o
);

  localparam int W = N + 3;

  // chain[i] is the carry entering column i; chain[N] leaves the row
  logic [N:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < N; i++) begin : g_col
    cmp5_cell u_cell (
      .x1       (a_i[i]),
      .x2       (b_i[i]),
      .x3       (c_i[i]),
      .x4       (d_i[i]),
      .cin      (chain[i]),
      .sum_o    (sum_o[i]),
      .vcarry_o (vcarry_o[i]),
      .hcarry_o (chain[i+1])
    );
  end

  assign hcarry_o = chain[N];

  // R7: weighted row total is preserved
  logic [W-1:0] tot_in, tot_out;
  always_comb begin
    tot_in  = W'(a_i) + W'(b_i) + W'(c_i) + W'(d_i) + W'(cin_i);
    tot_out = W'(sum_o) + (W'(vcarry_o) << 1) + (W'(hcarry_o) << N);
    a_r7_row_total: assert (tot_in == tot_out)
      else $error("R7 row total not preserved");
  end

endmodule

// File: tb/tb_cmp5_row.sv
`timescale 1ns/1ps
module tb_cmp5_row;

  localparam int N = 16;
  localparam int W = N + 3;
  localparam int NV = 10;

  // entry = {a,b,c,d,cin, exp_sum, exp_vcarry, exp_hcarry}, applied to column 0
  localparam logic [7:0] VEC [NV] = '{
    8'b00000_000, 8'b11100_101, 8'b11111_111, 8'b00011_010, 8'b10010_010,
    8'b01001_010, 8'b11000_001, 8'b11011_011, 8'b00111_110, 8'b10100_001
  };

  logic clk;
  logic [N-1:0] a, b, c, d;
  logic cin;
  logic [N-1:0] s, v;
  logic h;

  int checks = 0;
  int fails  = 0;
  bit done = 0;

  cmp5_row #(.N(N)) dut (
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .cin_i(cin),
    .sum_o(s), .vcarry_o(v), .hcarry_o(h)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference from the requirement equations (R1, R2, R3, R5, R6)
  task automatic model(output logic [N-1:0] es, output logic [N-1:0] ev, output logic eh);
    logic carry = cin;
    for (int i = 0; i < N; i++) begin
      logic p = a[i] ^ b[i] ^ c[i];
      es[i] = p ^ d[i] ^ carry;
      ev[i] = (p & d[i]) | (p & carry) | (d[i] & carry);
      carry = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end
    eh = carry;
  endtask

  task automatic apply(input logic [N-1:0] ta, tb, tc, td, input logic tcin);
    @(posedge clk);
    a = ta; b = tb; c = tc; d = td; cin = tcin;
    @(negedge clk);
  endtask

  task automatic full_check(input string tag);
    logic [N-1:0] es, ev;
    logic eh;
    logic [W-1:0] tin, tout;
    model(es, ev, eh);
    chk({tag, " R1 sum"}, 64'(s), 64'(es));
    chk({tag, " R3 vcarry"}, 64'(v), 64'(ev));
    chk({tag, " R6 hcarry_o"}, 64'(h), 64'(eh));
    tin  = W'(a) + W'(b) + W'(c) + W'(d) + W'(cin);
    tout = W'(s) + (W'(v) << 1) + (W'(h) << N);
    chk({tag, " R7 total"}, 64'(tout), 64'(tin));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; c = '0; d = '0; cin = 1'b0;
    // quiet state: all-zero inputs give all-zero outputs
    apply('0, '0, '0, '0, 1'b0);
    chk("R1 idle sum", 64'(s), 64'd0);
    chk("R3 idle vcarry", 64'(v), 64'd0);
    chk("R6 idle hcarry", 64'(h), 64'd0);

    // table walk: column 0 pattern, column 1 shows the carry it sent up (R5)
    for (int k = 0; k < NV; k++) begin
      logic [7:0] e = VEC[k];
      apply(N'(e[7]), N'(e[6]), N'(e[5]), N'(e[4]), e[3]);
      chk("R1 table sum", 64'(s[0]), 64'(e[2]));
      chk("R3 table vcarry", 64'(v[0]), 64'(e[1]));
      chk("R2 R5 table hcarry", 64'(s[1]), 64'(e[0]));
      chk("R4 table count", 64'(int'(s[0]) + 2 * (int'(v[0]) + int'(s[1]))),
          64'($countones(e[7:3])));
    end

    // exhaustive per column: incoming carry from cin_i or the column below (R5)
    for (int col = 0; col < N; col++) begin
      for (int p = 0; p < 32; p++) begin
        logic [N-1:0] ta = '0, tb = '0, tc = '0, td = '0;
        logic tcin = 1'b0;
        ta[col] = p[4]; tb[col] = p[3]; tc[col] = p[2]; td[col] = p[1];
        if (col == 0) tcin = p[0];
        else begin ta[col-1] = p[0]; tb[col-1] = p[0]; end
        apply(ta, tb, tc, td, tcin);
        full_check("exh");
        chk("R2 exh hcarry ignores d and cin",
            64'((col == N-1) ? h : s[(col+1) % N] ^ 1'b0),
            64'((p[4] & p[3]) | (p[4] & p[2]) | (p[3] & p[2])));
      end
    end

    // random full rows, plus cin toggle isolation (R8)
    for (int r = 0; r < 300; r++) begin
      logic [N-1:0] ra = N'($urandom), rb = N'($urandom), rc = N'($urandom), rd = N'($urandom);
      logic [N-1:0] s0, v0;
      logic h0;
      apply(ra, rb, rc, rd, 1'b0);
      full_check("rnd");
      s0 = s; v0 = v; h0 = h;
      apply(ra, rb, rc, rd, 1'b1);
      full_check("rnd");
      chk("R8 upper sum unchanged", 64'(s[N-1:1]), 64'(s0[N-1:1]));
      chk("R8 upper vcarry unchanged", 64'(v[N-1:1]), 64'(v0[N-1:1]));
      chk("R8 hcarry_o unchanged", 64'(h), 64'(h0));
    end

    // corners: all ones, and alternating patterns
    apply('1, '1, '1, '1, 1'b1);
    full_check("ones");
    chk("R6 ones hcarry_o", 64'(h), 64'd1);
    apply({(N/2){2'b10}}, {(N/2){2'b01}}, {(N/2){2'b10}}, {(N/2){2'b01}}, 1'b1);
    full_check("alt");
    apply('1, '1, '0, '0, 1'b0);
    full_check("two-ones");
    chk("R2 two-ones hcarry_o", 64'(h), 64'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule